// File: doc/BRIEF.md
# Error Counter Bank with Sticky Interrupt Status

This block counts eight kinds of line and framing error events, one counter per kind, and reports counter overflow through a sticky 8-bit status word and a single interrupt line. Each counter takes a one-cycle event pulse. A per-counter mode bit selects the counter's behaviour:

- **Wrap:** the counter rolls over from all-ones to zero. Each roll-over sets its status bit.
- **Saturate:** the counter sets its status bit once, when it first reaches all-ones. It then stays there until software strobes that counter's clear input.

The host reads the status word and clears it in one cycle. A set that lands in the same cycle as the read is kept for the next read. A 2-bit framing-mode input holds at zero the status bits that have no meaning in the selected line format.

Each counter runs a two-state machine:

- **CNT_RUN:** counting.
- **CNT_HELD:** frozen at all-ones.

The machine has three transitions:

- **RUN→HELD:** an event in saturate mode brings the count to all-ones, or arrives when the count is already there.
- **HELD→RUN:** the clear strobe.
- **RUN→RUN:** any clear strobe, which also zeroes the count.

In HELD, events are ignored.

Top module: `errcnt_irq_bank`

## Requirements
- R1: After reset, `stat_o` is 8'h00, `irq_o` is 0, and every counter is zero in CNT_RUN.
- R2: Counter i drives status bit i. The bit meanings are: 7 excessive zeros, 6 X-bit disagreement, 5 line code violation, 4 far-end block error, 3 path parity, 2 frame error, 1 P-bit disagreement, 0 parity error.
- R3: With `sat_mode_i[i]`=0, each counter is CNT_W bits wide (default 16). The event that takes it from all-ones to zero sets bit i at the clock edge that samples that event. So bit i sets once per 2^CNT_W events.
- R4: With `sat_mode_i[i]`=1, the event that brings counter i to all-ones sets bit i. The counter then enters CNT_HELD. Later events neither change it nor set bit i again.
- R5: `cnt_clr_i[i]`=1 zeroes counter i and returns it to CNT_RUN. An event in the same cycle is discarded.
- R6: Status bits are sticky until read and set whatever the value of `irq_en_i`.
- R7: While `stat_rd_i`=1, `stat_o` shows the current word. At that edge, every bit is cleared.
- R8: A set that coincides with a read survives the clear and is visible after that edge.
- R9: `irq_o` = OR over i of (`stat_o[i]` AND `irq_en_i[i]`). It is combinational on `irq_en_i`.
- R10: With `frm_mode_i`=2'b01 (DS3 multiplexed framing), bits 4 and 3 are held at 0.
- R11: With `frm_mode_i`=2'b10 (E3 G.751), bits 6, 4, 3, 1 and 0 are held at 0. Only bits 7, 5 and 2 can set.
- R12: With `frm_mode_i`=2'b00 (DS3 C-bit) or 2'b11, all eight bits can set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | One-cycle error event per counter |
| sat_mode_i | input | 8 | Per-counter mode: 1 saturate, 0 wrap |
| cnt_clr_i | input | 8 | Per-counter clear strobe |
| irq_en_i | input | 8 | Per-bit interrupt enable |
| frm_mode_i | input | 2 | Line framing format selecting live status bits |
| stat_rd_i | input | 1 | Status read strobe, clears the word |
| stat_o | output | 8 | Sticky status word |
| irq_o | output | 1 | Counter interrupt |

## Verification
The hardest situation to reach from the ports is a roll-over or saturation hit that falls in exactly the same cycle as a status read, because a counter only overflows after 2^CNT_W events. The bench narrows CNT_W and drives long unbroken event runs to bring every counter to the brink. It then aims a read at the precise wrap edge. After that, seeded random events, reads, clears, mode-bit changes and framing-mode switches hit the same coincidence many more times. A bench model tracks every count and checks the result.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
    localparam int unsigned NUM_SRC = 8;

    localparam int unsigned SB_EXZ   = 7;
    localparam int unsigned SB_XDIS  = 6;
    localparam int unsigned SB_LCV   = 5;
    localparam int unsigned SB_FEBE  = 4;
    localparam int unsigned SB_PATH  = 3;
    localparam int unsigned SB_FRAME = 2;
    localparam int unsigned SB_PDIS  = 1;
    localparam int unsigned SB_PAR   = 0;

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_HELD = 1'b1
    } cnt_state_e;

    typedef enum logic [1:0] {
        FRM_DS3_CBIT = 2'b00,
        FRM_DS3_MUX  = 2'b01,
        FRM_E3_751   = 2'b10,
        FRM_OTHER    = 2'b11
    } frm_mode_e;
endpackage

// File: rtl/errcnt_unit.sv
module errcnt_unit
    import errcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic sat_i,
    output logic hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit_d;

    // next-state and output process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hit_d   = 1'b0;
        if (clr_i) begin
            state_d = CNT_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CNT_RUN: begin
                    if (evt_i) begin
                        if (sat_i) begin
                            if (cnt_q >= CNT_PRE) begin
                                cnt_d   = CNT_MAX;
                                state_d = CNT_HELD;
                                hit_d   = 1'b1;
                            end else begin
                                cnt_d = cnt_q + 1'b1;
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                            hit_d = (cnt_q == CNT_MAX);
                        end
                    end
                end
                CNT_HELD: begin
                    cnt_d = cnt_q;
                end
                default: begin
                    state_d = CNT_RUN;
                end
            endcase
        end
    end

    assign hit_o = hit_d;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    a_r4_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HELD && !clr_i) |=> (state_q == CNT_HELD && $stable(cnt_q)));
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !sat_i) |=> (cnt_q == '0));
    a_r5_clear_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0 && state_q == CNT_RUN));
    a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && sat_i) |=> !hit_o);
endmodule

// File: rtl/errcnt_mode_mask.sv
module errcnt_mode_mask
    import errcnt_pkg::*;
(
    input  logic [1:0]         mode_i,
    output logic [NUM_SRC-1:0] live_o
);
    always_comb begin
        live_o = '1;
        unique case (frm_mode_e'(mode_i))
            FRM_DS3_CBIT: live_o = '1;
            FRM_DS3_MUX: begin
                live_o[SB_FEBE] = 1'b0;
                live_o[SB_PATH] = 1'b0;
            end
            FRM_E3_751: begin
                live_o[SB_XDIS] = 1'b0;
                live_o[SB_FEBE] = 1'b0;
                live_o[SB_PATH] = 1'b0;
                live_o[SB_PDIS] = 1'b0;
                live_o[SB_PAR]  = 1'b0;
            end
            FRM_OTHER: live_o = '1;
            default: live_o = '1;
        endcase
    end
endmodule

// File: rtl/errcnt_status_reg.sv
module errcnt_status_reg
    import errcnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hit_i,
    input  logic [NUM_SRC-1:0] live_i,
    input  logic               rd_i,
    output logic [NUM_SRC-1:0] stat_o
);
    logic [NUM_SRC-1:0] stat_q, kept;

    always_comb kept = rd_i ? '0 : stat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (kept | hit_i) & live_i;
    end

    assign stat_o = stat_q;

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((stat_q & ~$past(hit_i)) == '0));
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (($past(stat_q) & $past(live_i) & ~stat_q) == '0));
    a_r10_dead_low: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(live_i)) == '0));
    a_r8_hit_survives: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((($past(hit_i) & $past(live_i)) & ~stat_q) == '0));
endmodule

// File: rtl/errcnt_irq_bank.sv
module errcnt_irq_bank
    import errcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] evt_i,
    input  logic [7:0] sat_mode_i,
    input  logic [7:0] cnt_clr_i,
    input  logic [7:0] irq_en_i,
    input  logic [1:0] frm_mode_i,
    input  logic       stat_rd_i,
    output logic [7:0] stat_o,
    output logic       irq_o
);
    logic [NUM_SRC-1:0] hit, live;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cnt
        errcnt_unit #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_i[g]),
            .clr_i (cnt_clr_i[g]),
            .sat_i (sat_mode_i[g]),
            .hit_o (hit[g])
        );
    end

    errcnt_mode_mask u_mask (
        .mode_i (frm_mode_i),
        .live_o (live)
    );

    errcnt_status_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .live_i (live),
        .rd_i   (stat_rd_i),
        .stat_o (stat_o)
    );

    assign irq_o = |(stat_o & irq_en_i);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (stat_o == 8'h00));
endmodule

// File: tb/errcnt_irq_bank_tb_top.sv
module errcnt_irq_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic clk = 1'b0;
    logic rst_n;
    logic [7:0] evt, sat, clr, en;
    logic [1:0] mode;
    logic rd;
    logic [7:0] stat;
    logic irq;

    logic [CNT_W-1:0] m_cnt [8];
    bit   m_held [8];
    logic [7:0] m_stat;
    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errcnt_irq_bank #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sat_mode_i(sat),
        .cnt_clr_i(clr), .irq_en_i(en), .frm_mode_i(mode),
        .stat_rd_i(rd), .stat_o(stat), .irq_o(irq)
    );

    function automatic logic [7:0] live_bits(logic [1:0] m);
        case (m)
            2'b01:   return 8'hE7;
            2'b10:   return 8'hA4;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_edge();
        logic [7:0] hits = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (clr[i]) begin
                m_cnt[i] = '0; m_held[i] = 0;
            end else if (evt[i] && !m_held[i]) begin
                if (sat[i]) begin
                    if (m_cnt[i] >= MAXV - 1'b1) begin
                        m_cnt[i] = MAXV; m_held[i] = 1; hits[i] = 1'b1;
                    end else m_cnt[i] = m_cnt[i] + 1'b1;
                end else begin
                    if (m_cnt[i] == MAXV) hits[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + 1'b1;
                end
            end
        end
        m_stat = ((rd ? 8'h00 : m_stat) | hits) & live_bits(mode);
    endtask

    task automatic compare();
        logic exp_irq = |(m_stat & en);
        n_cmp++;
        if (stat !== m_stat) begin
            n_bad++;
            $display("FAIL %s stat: actual=%h expected=%h", cur_req, stat, m_stat);
        end
        n_cmp++;
        if (irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s irq: actual=%b expected=%b", cur_req, irq, exp_irq);
        end
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic read_once();
        rd = 1'b1; cyc(1); rd = 1'b0;
    endtask

    task automatic clear_all();
        evt = '0; clr = 8'hFF; cyc(1); clr = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; evt = '0; sat = '0; clr = '0; en = '0; mode = 2'b00; rd = 1'b0;
        for (int i = 0; i < 8; i++) begin m_cnt[i] = '0; m_held[i] = 0; end
        m_stat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; compare();
        cyc(2);

        // R3 / R6: wrap on every counter, interrupt disabled
        cur_req = "R3"; evt = 8'hFF; sat = 8'h00; en = 8'h00;
        cyc(255);
        cur_req = "R6"; cyc(1);
        evt = '0; cyc(3);
        cur_req = "R9"; en = 8'h10; #1 compare();
        en = 8'h00; #1 compare();
        cur_req = "R7"; read_once(); cyc(2);

        // R2: only line code violation counter
        cur_req = "R2"; en = 8'hFF; evt = 8'h20; cyc(256); evt = '0; cyc(1);
        read_once();

        // R4: saturation, then continued events ignored
        cur_req = "R4"; clear_all(); sat = 8'hFF; evt = 8'hFF;
        cyc(260); read_once(); cyc(300); evt = '0; cyc(2);

        // R5: clear with simultaneous event, then restart
        cur_req = "R5"; evt = 8'hFF; clr = 8'h0F; cyc(1); clr = '0;
        cyc(254); read_once(); cyc(5); evt = '0; read_once();

        // R8: wrap hit coinciding with read
        cur_req = "R8"; clear_all(); sat = 8'h00; evt = 8'hFF; cyc(255);
        rd = 1'b1; cyc(1); rd = 1'b0; evt = '0; cyc(2);

        // R10 / R11 / R12 directed: wrap all counters under each framing mode
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            cur_req = (m == 1) ? "R10" : (m == 2) ? "R11" : "R12";
            read_once(); clear_all(); evt = 8'hFF; cyc(256); evt = '0; cyc(2);
        end

        // random mix across all framing modes
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            cur_req = (m == 1) ? "R10" : (m == 2) ? "R11" : "R12";
            for (int k = 0; k < 6000; k++) begin
                if (k % 700 == 0) sat = 8'($urandom);
                if (k % 90 == 0)  en  = 8'($urandom);
                evt = 8'($urandom | $urandom);
                rd  = ($urandom % 37 == 0);
                clr = ($urandom % 150 == 0) ? 8'($urandom) : 8'h00;
                cyc(1);
            end
            rd = 1'b0; clr = '0; evt = '0;
        end

        cur_req = "R9"; en = 8'hFF; cyc(2);
        done = 1;
        summary();
        $finish;
    end
endmodule